// File: doc/BRIEF.md
# Multichannel DAC Special-Function Command Controller

This block receives command words for a 32-channel, 12-bit converter register file and carries out the global special functions: loading a clear code, clearing every channel to that code, entering and leaving power-down, software reset and a no-operation word. Each word comes with a two-bit register-class selector, a five-bit function address and a twelve-bit data field. The block acts only on words whose selector is zero. All other words belong to neighbouring logic and are passed over here.

The block owns the clear-code register and the per-channel data, gain and offset registers. It also holds the software power-down flag. Timed operations hold an active-low busy output for a parameterised number of clock cycles. During that window the block sweeps one channel per cycle, so that every channel holds its new value by the time busy is released. An active-low hardware clear input and an active-high hardware power-down input sit beside the command port. A combinational read port exposes any channel's registers.

Top module: `dac_sfc_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy_n is 1 and pd_active is 0. The clear code is 0. Every channel holds data 0x000, gain 0xFFF and offset 0x000.
- R2: A word is decoded only when cmd_sel is 2'b00. A word with any other selector, a function code outside the set listed in R3, R4, R6, R8 and R9, or the no-operation code 5'b00000 changes no state and does not start busy.
- R3: Function code 5'b00001 stores cmd_data in the clear code, which is visible on clr_code one cycle after the command is taken.
- R4: Function code 5'b00010 (soft clear) drives busy_n low for exactly CLR_CYC cycles, starting in the cycle after the command. When busy_n returns high, every channel's data equals the clear code. The data field of this command is ignored.
- R5: When hw_clr_n is sampled low while the block is idle and not powered down, it starts the same clear operation as R4. If a command arrives in the same cycle, the hardware clear wins and the command is dropped.
- R6: Function code 5'b01000 sets the software power-down flag. pd_active is the OR of that flag and hw_pd.
- R7: While pd_active is 1, a clear-code write, a soft clear and a hardware clear have no effect: busy_n stays 1 and no register changes.
- R8: Function code 5'b01001 (soft power-up) drives busy_n low for exactly PU_CYC cycles. pd_active remains 1 through that window, and the software flag clears when busy_n is released.
- R9: Function code 5'b01111 (soft reset) clears the clear code and the software power-down flag in the cycle after the command. It drives busy_n low for exactly RST_CYC cycles. On release, every channel holds data 0, gain 0xFFF and offset 0. Soft reset is accepted while powered down.
- R10: While busy_n is 0, every command and any hardware clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_sel | input | 2 | Register-class selector; 00 selects special functions |
| cmd_addr | input | 5 | Function code |
| cmd_data | input | 12 | Data field |
| hw_clr_n | input | 1 | Active-low hardware clear request |
| hw_pd | input | 1 | Active-high hardware power-down request |
| rd_ch | input | 5 | Channel selected for readout |
| busy_n | output | 1 | Low while a timed operation runs |
| pd_active | output | 1 | Effective power-down state |
| clr_code | output | 12 | Current clear code |
| rd_data | output | 12 | Data register of channel rd_ch |
| rd_gain | output | 12 | Gain register of channel rd_ch |
| rd_offset | output | 12 | Offset register of channel rd_ch |

## Verification
A command or hardware clear taken at a clock edge shows its effect right after that edge. The clear code, the power-down flag and busy_n low all appear there, one register deep, so the bench drives on falling edges and samples on the next falling edge. Busy duration is measured by counting falling edges while busy_n is low, and the count must equal the parameter exactly. Channel contents are read through the combinational read port only after busy_n has returned high, which is the point where R4 and R9 promise that the sweep is complete. Rejected stimulus (power-down lockout, busy lockout, foreign selectors) is checked by observing busy_n and clr_code in the cycle after it, and by reading back every channel.

// File: rtl/sfc_pkg.sv
// Package: shared function codes and operation kinds for the special-function
// controller. Assumes a 5-bit function field and a 2-bit class selector.
package sfc_pkg;
    localparam logic [4:0] FN_NOP     = 5'b00000;
    localparam logic [4:0] FN_SETCODE = 5'b00001;
    localparam logic [4:0] FN_CLEAR   = 5'b00010;
    localparam logic [4:0] FN_PDOWN   = 5'b01000;
    localparam logic [4:0] FN_PUP     = 5'b01001;
    localparam logic [4:0] FN_RESET   = 5'b01111;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_PUP   = 2'd2,
        OP_RESET = 2'd3
    } op_e;

    typedef struct packed {
        logic setcode;
        logic clear;
        logic pdown;
        logic pup;
        logic reset;
    } fn_t;
endpackage

// File: rtl/sfc_cmd_decode.sv
// Module: combinational decode of a command word into one-hot function strobes.
// Assumes: only selector 00 is owned here; NOP and unknown codes yield no strobe.
module sfc_cmd_decode
    import sfc_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] sel,
    input  logic [4:0] addr,
    output fn_t        fn
);
    logic own;
    assign own = valid && (sel == 2'b00);

    // Map the function field to its strobe.
    always_comb begin
        fn         = '0;
        fn.setcode = own && (addr == FN_SETCODE);
        fn.clear   = own && (addr == FN_CLEAR);
        fn.pdown   = own && (addr == FN_PDOWN);
        fn.pup     = own && (addr == FN_PUP);
        fn.reset   = own && (addr == FN_RESET);
    end
endmodule

// File: rtl/sfc_busy_timer.sv
// Module: holds an operation active for a duration chosen by its kind.
// Assumes: start only arrives while inactive; every duration is at least 1.
module sfc_busy_timer
    import sfc_pkg::*;
#(
    parameter int CLR_CYC = 3500,
    parameter int PU_CYC  = 800,
    parameter int RST_CYC = 13500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  start_op,
    output logic active,
    output op_e  op,
    output logic last
);
    localparam int MAXC = (CLR_CYC > PU_CYC) ?
                          ((CLR_CYC > RST_CYC) ? CLR_CYC : RST_CYC) :
                          ((PU_CYC > RST_CYC) ? PU_CYC : RST_CYC);
    localparam int CW = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load;

    // Pick the reload value for the requested operation.
    always_comb begin
        case (start_op)
            OP_CLEAR: load = CW'(CLR_CYC - 1);
            OP_PUP:   load = CW'(PU_CYC - 1);
            OP_RESET: load = CW'(RST_CYC - 1);
            default:  load = '0;
        endcase
    end

    assign last = active && (cnt == '0);

    // Count down the active window and drop it after the final cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            op     <= OP_IDLE;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            op     <= start_op;
            cnt    <= load;
        end else if (last) begin
            active <= 1'b0;
            op     <= OP_IDLE;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/sfc_chan_regs.sv
// Module: per-channel data, gain and offset registers with a one-channel-per-
// cycle sweep loader. Assumes the sweep window lasts at least NCH cycles.
module sfc_chan_regs #(
    parameter int NCH = 32,
    parameter int DW  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sweep_start,
    input  logic                   sweep_en,
    input  logic                   sweep_dflt,
    input  logic [DW-1:0]          sweep_val,
    input  logic [$clog2(NCH)-1:0] rd_ch,
    output logic [DW-1:0]          rd_data,
    output logic [DW-1:0]          rd_gain,
    output logic [DW-1:0]          rd_offset
);
    localparam int CHW = $clog2(NCH);
    localparam int IW  = CHW + 1;

    logic [IW-1:0] idx;
    logic [DW-1:0] data_q [NCH];
    logic [DW-1:0] gain_q [NCH];
    logic [DW-1:0] offs_q [NCH];

    // Step the sweep index until every channel has been written.
    always_ff @(posedge clk) begin
        if (!rst_n || sweep_start) begin
            idx <= '0;
        end else if (sweep_en && (idx < IW'(NCH))) begin
            idx <= idx + 1'b1;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = sweep_en && (idx == IW'(i));
        // Load this channel when the sweep reaches it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                gain_q[i] <= '1;
                offs_q[i] <= '0;
            end else if (hit) begin
                data_q[i] <= sweep_val;
                if (sweep_dflt) begin
                    gain_q[i] <= '1;
                    offs_q[i] <= '0;
                end
            end
        end
    end

    assign rd_data   = data_q[rd_ch];
    assign rd_gain   = gain_q[rd_ch];
    assign rd_offset = offs_q[rd_ch];
endmodule

// File: rtl/dac_sfc_ctrl.sv
// Module: top of the special-function controller. Arbitrates hardware clear
// against commands, applies busy and power-down lockouts, keeps the clear code
// and the software power-down flag. Assumes CLR_CYC and RST_CYC >= NCH.
module dac_sfc_ctrl
    import sfc_pkg::*;
#(
    parameter int NCH     = 32,
    parameter int DW      = 12,
    parameter int CLR_CYC = 3500,
    parameter int PU_CYC  = 800,
    parameter int RST_CYC = 13500
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_sel,
    input  logic [4:0]             cmd_addr,
    input  logic [DW-1:0]          cmd_data,
    input  logic                   hw_clr_n,
    input  logic                   hw_pd,
    input  logic [$clog2(NCH)-1:0] rd_ch,
    output logic                   busy_n,
    output logic                   pd_active,
    output logic [DW-1:0]          clr_code,
    output logic [DW-1:0]          rd_data,
    output logic [DW-1:0]          rd_gain,
    output logic [DW-1:0]          rd_offset
);
    fn_t  fn;
    logic active, last, sw_pd;
    op_e  op, start_op;
    logic take_hw, cmd_ok, go_clear, go_pup, go_reset, start, wr_code;

    sfc_cmd_decode u_dec (
        .valid (cmd_valid),
        .sel   (cmd_sel),
        .addr  (cmd_addr),
        .fn    (fn)
    );

    // Arbitration: hardware clear first, then commands, only while idle.
    assign take_hw  = !active && !pd_active && !hw_clr_n;
    assign cmd_ok   = !active && !take_hw;
    assign go_clear = take_hw || (cmd_ok && fn.clear && !pd_active);
    assign go_pup   = cmd_ok && fn.pup;
    assign go_reset = cmd_ok && fn.reset;
    assign wr_code  = cmd_ok && fn.setcode && !pd_active;
    assign start    = go_clear || go_pup || go_reset;

    // Choose the operation kind handed to the timer.
    always_comb begin
        if (go_reset)      start_op = OP_RESET;
        else if (go_pup)   start_op = OP_PUP;
        else if (go_clear) start_op = OP_CLEAR;
        else               start_op = OP_IDLE;
    end

    sfc_busy_timer #(
        .CLR_CYC (CLR_CYC),
        .PU_CYC  (PU_CYC),
        .RST_CYC (RST_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_op (start_op),
        .active   (active),
        .op       (op),
        .last     (last)
    );

    // Clear-code register: written by command, zeroed by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || go_reset) begin
            clr_code <= '0;
        end else if (wr_code) begin
            clr_code <= cmd_data;
        end
    end

    // Software power-down flag: set by command, cleared by reset or power-up end.
    always_ff @(posedge clk) begin
        if (!rst_n || go_reset) begin
            sw_pd <= 1'b0;
        end else if (last && (op == OP_PUP)) begin
            sw_pd <= 1'b0;
        end else if (cmd_ok && fn.pdown) begin
            sw_pd <= 1'b1;
        end
    end

    assign pd_active = sw_pd || hw_pd;
    assign busy_n    = !active;

    sfc_chan_regs #(
        .NCH (NCH),
        .DW  (DW)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sweep_start (start),
        .sweep_en    (active && (op == OP_CLEAR || op == OP_RESET)),
        .sweep_dflt  (op == OP_RESET),
        .sweep_val   ((op == OP_RESET) ? '0 : clr_code),
        .rd_ch       (rd_ch),
        .rd_data     (rd_data),
        .rd_gain     (rd_gain),
        .rd_offset   (rd_offset)
    );
endmodule

// File: rtl/dac_sfc_ctrl_chk.sv
// Module: property checker for dac_sfc_ctrl, attached by bind below.
// Assumes it sees only the top module's ports.
module dac_sfc_ctrl_chk #(
    parameter int DW      = 12,
    parameter int CLR_CYC = 3500,
    parameter int PU_CYC  = 800,
    parameter int RST_CYC = 13500
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_sel,
    input logic [4:0]    cmd_addr,
    input logic [DW-1:0] cmd_data,
    input logic          hw_clr_n,
    input logic          hw_pd,
    input logic          busy_n,
    input logic          pd_active,
    input logic [DW-1:0] clr_code
);
    int run;
    logic own, wake;
    assign own  = cmd_valid && (cmd_sel == 2'b00);
    assign wake = own && (cmd_addr == 5'b01001 || cmd_addr == 5'b01111);

    // Length of the current low stretch of busy_n.
    always_ff @(posedge clk) begin
        if (!rst_n || busy_n) run <= 0;
        else                  run <= run + 1;
    end

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (run == CLR_CYC || run == PU_CYC || run == RST_CYC));

    assert_foreign_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_sel != 2'b00 && busy_n && hw_clr_n) |=> (busy_n && $stable(clr_code)));

    assert_code_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (own && cmd_addr == 5'b00001 && busy_n && hw_clr_n && !pd_active) |=> (clr_code == $past(cmd_data)));

    assert_hw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_clr_n && busy_n && !pd_active) |=> !busy_n);

    assert_hw_pd_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_pd |-> pd_active);

    assert_soft_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own && cmd_addr == 5'b01000 && busy_n && hw_clr_n) |=> pd_active);

    assert_pd_lockout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && busy_n && !wake) |=> (busy_n && $stable(clr_code)));

    assert_busy_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n |=> $stable(clr_code));
endmodule

bind dac_sfc_ctrl dac_sfc_ctrl_chk #(
    .DW      (DW),
    .CLR_CYC (CLR_CYC),
    .PU_CYC  (PU_CYC),
    .RST_CYC (RST_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_sel   (cmd_sel),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .hw_clr_n  (hw_clr_n),
    .hw_pd     (hw_pd),
    .busy_n    (busy_n),
    .pd_active (pd_active),
    .clr_code  (clr_code)
);

// File: tb/dac_sfc_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module dac_sfc_ctrl_tb;
    localparam int PERIOD = 10;
    localparam int NCH = 32;
    localparam int DW  = 12;
    localparam int CLR = 40;
    localparam int PU  = 10;
    localparam int RST = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_sel = '0;
    logic [4:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic hw_clr_n = 1'b1;
    logic hw_pd = 1'b0;
    logic [4:0] rd_ch = '0;
    logic busy_n, pd_active;
    logic [DW-1:0] clr_code, rd_data, rd_gain, rd_offset;
    int checks = 0;
    int errs = 0;

    always #(PERIOD/2) clk = !clk;

    dac_sfc_ctrl #(.NCH(NCH), .DW(DW), .CLR_CYC(CLR), .PU_CYC(PU), .RST_CYC(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .hw_clr_n(hw_clr_n), .hw_pd(hw_pd),
        .rd_ch(rd_ch), .busy_n(busy_n), .pd_active(pd_active), .clr_code(clr_code),
        .rd_data(rd_data), .rd_gain(rd_gain), .rd_offset(rd_offset));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one word for one cycle; returns at the falling edge after it is sampled.
    task automatic send(input logic [1:0] s, input logic [4:0] a, input logic [DW-1:0] d);
        cmd_valid = 1'b1; cmd_sel = s; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_sel = '0; cmd_addr = '0; cmd_data = '0;
    endtask

    // Count remaining falling edges with busy_n low.
    task automatic wait_busy(input string req, input int exp);
        int n = 0;
        while (!busy_n && n < 100000) begin n++; @(negedge clk); end
        check(req, n, exp);
    endtask

    task automatic check_chans(input string req, input int d, input int g, input int o);
        int bad = 0;
        for (int i = 0; i < NCH; i++) begin
            rd_ch = 5'(i); #1;
            if (rd_data != DW'(d) || rd_gain != DW'(g) || rd_offset != DW'(o)) bad++;
        end
        check({req, " channels mismatching"}, bad, 0);
    endtask

    task automatic t_reset_state;
        check("R1 busy_n", busy_n, 1);
        check("R1 pd_active", pd_active, 0);
        check("R1 clr_code", clr_code, 0);
        check_chans("R1", 0, 'hFFF, 0);
    endtask

    task automatic t_set_code;
        send(2'b00, 5'b00001, 12'hA5C);
        check("R3 clr_code", clr_code, 'hA5C);
        check("R3 no busy", busy_n, 1);
    endtask

    task automatic t_soft_clear;
        send(2'b00, 5'b00010, 12'h123);
        check("R4 busy start", busy_n, 0);
        wait_busy("R4 busy length", CLR);
        check_chans("R4", 'hA5C, 'hFFF, 0);
        check("R4 data ignored", clr_code, 'hA5C);
    endtask

    task automatic t_busy_lockout;
        send(2'b00, 5'b00010, 12'h0);
        send(2'b00, 5'b00001, 12'h111);
        send(2'b00, 5'b01000, 12'h0);
        wait_busy("R10 remaining busy", CLR - 2);
        check("R10 code kept", clr_code, 'hA5C);
        check("R10 pd ignored", pd_active, 0);
    endtask

    task automatic t_hw_clear;
        send(2'b00, 5'b00001, 12'h3C3);
        hw_clr_n = 1'b0;
        send(2'b00, 5'b00001, 12'h999);
        hw_clr_n = 1'b1;
        check("R5 busy start", busy_n, 0);
        wait_busy("R5 busy length", CLR);
        check("R5 command dropped", clr_code, 'h3C3);
        check_chans("R5", 'h3C3, 'hFFF, 0);
    endtask

    task automatic t_foreign;
        send(2'b01, 5'b00001, 12'h555);
        check("R2 selector 01 code", clr_code, 'h3C3);
        send(2'b11, 5'b00010, 12'h0);
        check("R2 selector 11 busy", busy_n, 1);
        send(2'b00, 5'b00011, 12'h0);
        send(2'b00, 5'b01100, 12'h0);
        check("R2 unknown code busy", busy_n, 1);
        send(2'b00, 5'b00000, 12'hFFF);
        check("R2 nop code", clr_code, 'h3C3);
        check("R2 nop pd", pd_active, 0);
        check_chans("R2", 'h3C3, 'hFFF, 0);
    endtask

    task automatic t_power;
        send(2'b00, 5'b01000, 12'h0);
        check("R6 soft pd", pd_active, 1);
        send(2'b00, 5'b00001, 12'h777);
        check("R7 code locked", clr_code, 'h3C3);
        send(2'b00, 5'b00010, 12'h0);
        check("R7 soft clear busy", busy_n, 1);
        hw_clr_n = 1'b0; @(negedge clk); hw_clr_n = 1'b1;
        check("R7 hw clear busy", busy_n, 1);
        check_chans("R7", 'h3C3, 'hFFF, 0);
        send(2'b00, 5'b01001, 12'h0);
        check("R8 busy start", busy_n, 0);
        check("R8 pd held", pd_active, 1);
        wait_busy("R8 busy length", PU);
        check("R8 pd released", pd_active, 0);
        hw_pd = 1'b1; #1;
        check("R6 hw pd", pd_active, 1);
        hw_pd = 1'b0; #1;
        check("R6 hw pd off", pd_active, 0);
    endtask

    task automatic t_soft_reset;
        send(2'b00, 5'b01000, 12'h0);
        send(2'b00, 5'b01111, 12'hABC);
        check("R9 code zeroed", clr_code, 0);
        check("R9 pd cleared", pd_active, 0);
        check("R9 busy start", busy_n, 0);
        wait_busy("R9 busy length", RST);
        check_chans("R9", 0, 'hFFF, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_set_code();
        t_soft_clear();
        t_busy_lockout();
        t_hw_clear();
        t_foreign();
        t_power();
        t_soft_reset();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule